// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block works out where a 32-bit core fetches next. Each cycle it takes the address of the current instruction, the instruction word and the two source operand values already read from the register file. From these it produces the next fetch address. For the two link-and-jump forms it also produces a register-file write request that carries the return address.

It handles six control transfers. Two are conditional branches relative to the following instruction: one taken on equality and one on inequality. Two are region jumps to an absolute word index, one plain and one that links. Two jump through a register, one plain and one that links. Every other instruction falls through to the next sequential word.

The result is captured in output registers on each rising clock edge, so it appears one cycle after its inputs. A synchronous active-high reset returns those registers to a programmable start address with no link request.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs load `npc_o` = RESET_PC (default 0), `link_we_o` = 0, `link_rd_o` = 0 and `link_val_o` = 0, whatever the other inputs are.
- R2: All outputs are registered. They change only at a rising edge and reflect the inputs sampled at that edge, so the latency is one cycle.
- R3: An instruction whose opcode (bits 31:26) is not 0, 2, 3, 4 or 5 gives `npc_o` = PC+4 and `link_we_o` = 0.
- R4: Opcode 4 (branch if equal) gives PC+4 + (sign-extended bits 15:0 shifted left by 2) when `rs_val_i` equals `rt_val_i`, and PC+4 otherwise. It requests no link.
- R5: Opcode 5 (branch if not equal) takes the same target when the operands differ, and gives PC+4 when they are equal. It requests no link.
- R6: Opcode 2 (jump) gives {PC[31:28], bits 25:0, 2'b00}, taking the upper four bits from the current PC. It requests no link.
- R7: Opcode 3 (jump and link) jumps as in R6 and asserts `link_we_o` with `link_rd_o` = 31. Whenever reset is not applied, `link_val_o` is PC+4 of the captured instruction.
- R8: Opcode 0 with function field (bits 5:0) 8 (register jump) gives `npc_o` = `rs_val_i`. It requests no link.
- R9: Opcode 0 with function 9 (register jump and link) gives `npc_o` = `rs_val_i`, `link_rd_o` = bits 15:11 and `link_we_o` = 1. When bits 15:11 are zero, no write is requested: `link_we_o` = 0 and `link_rd_o` = 0.
- R10: Opcode 0 with any function other than 8 or 9 falls through to PC+4 with no link.
- R11: Branch targets wrap modulo 2^32. The extreme offsets 0x7FFF and 0x8000 move the target by +131068 and -131072 bytes from PC+4.
- R12: `link_we_o` is never high together with `link_rd_o` = 0, and it is high only for the two linking forms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value read for the first source register |
| rt_val_i | input | 32 | Value read for the second source register |
| npc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Return-address write request |
| link_rd_o | output | 5 | Destination register of the return address |
| link_val_o | output | 32 | Return address, PC+4 |

## Verification
The bench tests both branch kinds on each side of their compare. A design with the condition swapped or stuck would send the not-taken case to the target, or the taken case to the fall-through address. The extreme positive and negative offsets, and a negative offset that lands below PC+4, expose a missing sign extension, a missing word scaling, or a base of PC instead of PC+4.

The region jumps are tested with PCs whose top nibble is nonzero and with the largest word index. A design that used PC+4 for the upper bits, or that dropped the shift, would return the wrong region or an unaligned address. The register jump and link is tested with destination 0, where a careless design still raises a write request. Mid-stream reset and the one-cycle latency are tested directly.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int INSTR_W  = 32;
  localparam int OPC_W    = 6;
  localparam int FUNC_W   = 6;
  localparam int OFF_W    = 16;
  localparam int IDX_W    = 26;
  localparam int RA_W     = 5;

  localparam int OPC_LSB  = 26;
  localparam int RD_LSB   = 11;

  localparam logic [OPC_W-1:0]  OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0]  OPC_J       = 6'd2;
  localparam logic [OPC_W-1:0]  OPC_JAL     = 6'd3;
  localparam logic [OPC_W-1:0]  OPC_BEQ     = 6'd4;
  localparam logic [OPC_W-1:0]  OPC_BNE     = 6'd5;
  localparam logic [FUNC_W-1:0] FN_JR       = 6'd8;
  localparam logic [FUNC_W-1:0] FN_JALR     = 6'd9;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BEQ,
    FLOW_BNE,
    FLOW_JMP,
    FLOW_JMPL,
    FLOW_REG,
    FLOW_REGL
  } flow_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FUNC_W-1:0] func_i,
  output flow_kind_e        kind_o
);

  always_comb begin
    kind_o = FLOW_SEQ;
    case (opc_i)
      OPC_SPECIAL: begin
        if (func_i == FN_JR)        kind_o = FLOW_REG;
        else if (func_i == FN_JALR) kind_o = FLOW_REGL;
      end
      OPC_J:   kind_o = FLOW_JMP;
      OPC_JAL: kind_o = FLOW_JMPL;
      OPC_BEQ: kind_o = FLOW_BEQ;
      OPC_BNE: kind_o = FLOW_BNE;
      default: kind_o = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [XLEN-1:0]  rt_val_i,
  input  flow_kind_e       kind_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  npc_o
);

  localparam int SEXT_W   = XLEN - OFF_W - 2;
  localparam int REGION_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] jmp_tgt;
  logic            ops_eq;

  assign seq_o   = pc_i + XLEN'(4);
  assign br_tgt  = seq_o + {{SEXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign jmp_tgt = {pc_i[XLEN-1 -: REGION_W], idx_i, 2'b00};
  assign ops_eq  = (rs_val_i == rt_val_i);

  always_comb begin
    npc_o = seq_o;
    case (kind_i)
      FLOW_BEQ:             if (ops_eq)  npc_o = br_tgt;
      FLOW_BNE:             if (!ops_eq) npc_o = br_tgt;
      FLOW_JMP, FLOW_JMPL:  npc_o = jmp_tgt;
      FLOW_REG, FLOW_REGL:  npc_o = rs_val_i;
      default:              npc_o = seq_o;
    endcase
  end

endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int             XLEN     = 32,
  parameter logic [RA_W-1:0] LINK_REG = 5'd31
) (
  input  flow_kind_e       kind_i,
  input  logic [RA_W-1:0]  rd_i,
  input  logic [XLEN-1:0]  seq_i,
  output logic             we_o,
  output logic [RA_W-1:0]  rd_o,
  output logic [XLEN-1:0]  val_o
);

  always_comb begin
    we_o = 1'b0;
    rd_o = '0;
    if (kind_i == FLOW_JMPL) begin
      we_o = 1'b1;
      rd_o = LINK_REG;
    end else if (kind_i == FLOW_REGL && rd_i != '0) begin
      we_o = 1'b1;
      rd_o = rd_i;
    end
  end

  assign val_o = seq_i;

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [RA_W-1:0] LINK_REG = 5'd31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic [XLEN-1:0]   npc_o,
  output logic              link_we_o,
  output logic [RA_W-1:0]   link_rd_o,
  output logic [XLEN-1:0]   link_val_o
);

  flow_kind_e      kind;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] npc_d;
  logic            we_d;
  logic [RA_W-1:0] rd_d;
  logic [XLEN-1:0] val_d;
  logic            live_q;

  npc_decode u_dec (
    .opc_i  (instr_i[OPC_LSB +: OPC_W]),
    .func_i (instr_i[FUNC_W-1:0]),
    .kind_o (kind)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (instr_i[OFF_W-1:0]),
    .idx_i    (instr_i[IDX_W-1:0]),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .kind_i   (kind),
    .seq_o    (seq_pc),
    .npc_o    (npc_d)
  );

  npc_link #(.XLEN(XLEN), .LINK_REG(LINK_REG)) u_lnk (
    .kind_i (kind),
    .rd_i   (instr_i[RD_LSB +: RA_W]),
    .seq_i  (seq_pc),
    .we_o   (we_d),
    .rd_o   (rd_d),
    .val_o  (val_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc_o      <= RESET_PC;
      link_we_o  <= 1'b0;
      link_rd_o  <= '0;
      link_val_o <= '0;
      live_q     <= 1'b0;
    end else begin
      npc_o      <= npc_d;
      link_we_o  <= we_d;
      link_rd_o  <= rd_d;
      link_val_o <= val_d;
      live_q     <= 1'b1;
    end
  end

  // R12: a write request never targets register 0
  a_r12_no_zero_dest: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_rd_o != '0));

  // R7: return address is the word after the captured instruction
  a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (link_val_o == $past(pc_i) + XLEN'(4)));

  // R6: region jumps keep the upper PC bits and stay word aligned
  a_r6_region_keep: assert property (@(posedge clk) disable iff (rst)
    (live_q && ($past(instr_i[OPC_LSB +: OPC_W]) == OPC_J ||
                $past(instr_i[OPC_LSB +: OPC_W]) == OPC_JAL))
    |-> (npc_o[XLEN-1 -: 4] == $past(pc_i[XLEN-1 -: 4]) && npc_o[1:0] == 2'b00));

  // R8: a plain register jump follows the first operand and never links
  a_r8_reg_jump: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_SPECIAL &&
     $past(instr_i[FUNC_W-1:0]) == FN_JR)
    |-> (npc_o == $past(rs_val_i) && !link_we_o));

  // R4: a branch-if-equal with differing operands falls through
  a_r4_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(instr_i[OPC_LSB +: OPC_W]) == OPC_BEQ &&
     $past(rs_val_i) != $past(rt_val_i))
    |-> (npc_o == $past(pc_i) + XLEN'(4)));

  // R3: non-control opcodes fall through without linking
  a_r3_plain_seq: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(instr_i[OPC_LSB +: OPC_W]) > OPC_BNE)
    |-> (npc_o == $past(pc_i) + XLEN'(4) && !link_we_o));

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  // tag, pc, instr, rs, rt, expected npc, expected we, expected rd
  localparam logic [23:0] T_TAG [NV] = '{
    "R4 ", "R4 ", "R4 ", "R5 ", "R5 ", "R6 ", "R7 ", "R8 ",
    "R9 ", "R9 ", "R3 ", "R3 ", "R10", "R11", "R11", "R6 "};
  localparam logic [31:0] T_PC [NV] = '{
    32'h00400000, 32'h00400000, 32'h00400100, 32'h00001000,
    32'h00001004, 32'hA0000010, 32'h3FFFFFFC, 32'h00000100,
    32'h00000200, 32'h00000300, 32'h00000500, 32'h00000600,
    32'h00000700, 32'h00000000, 32'h00010000, 32'hFFFFFFF0};
  localparam logic [31:0] T_IN [NV] = '{
    32'h10000003, 32'h10000003, 32'h1000FFFE, 32'h14000010,
    32'h14000010, 32'h08123456, 32'h0FFFFFFF, 32'h01000008,
    32'h01202809, 32'h01200009, 32'h01095020, 32'h2109FFFD,
    32'h0000000A, 32'h10007FFF, 32'h10008000, 32'h08000000};
  localparam logic [31:0] T_A [NV] = '{
    32'd5, 32'd5, 32'd7, 32'd1, 32'd3, 32'd0, 32'd0, 32'h12345678,
    32'h00008000, 32'hDEADBEEC, 32'd1, 32'd1, 32'd0, 32'd9, 32'd9, 32'd0};
  localparam logic [31:0] T_B [NV] = '{
    32'd5, 32'd6, 32'd7, 32'd2, 32'd3, 32'd0, 32'd0, 32'd0,
    32'd0, 32'd0, 32'd2, 32'd2, 32'd0, 32'd9, 32'd9, 32'd0};
  localparam logic [31:0] T_NPC [NV] = '{
    32'h00400010, 32'h00400004, 32'h004000FC, 32'h00001044,
    32'h00001008, 32'hA048D158, 32'h3FFFFFFC, 32'h12345678,
    32'h00008000, 32'hDEADBEEC, 32'h00000504, 32'h00000604,
    32'h00000704, 32'h00020000, 32'hFFFF0004, 32'hF0000000};
  localparam logic T_WE [NV] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [4:0] T_RD [NV] = '{
    5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd31, 5'd0,
    5'd5, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] rt_val_i = '0;
  logic [31:0] npc_o;
  logic        link_we_o;
  logic [4:0]  link_rd_o;
  logic [31:0] link_val_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit uut (
    .clk        (clk),
    .rst        (rst),
    .pc_i       (pc_i),
    .instr_i    (instr_i),
    .rs_val_i   (rs_val_i),
    .rt_val_i   (rt_val_i),
    .npc_o      (npc_o),
    .link_we_o  (link_we_o),
    .link_rd_o  (link_rd_o),
    .link_val_o (link_val_o)
  );

  task automatic chk(input logic [23:0] tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 ", "npc", npc_o, 32'h0);
    chk("R1 ", "we", {31'd0, link_we_o}, 32'd0);
    chk("R1 ", "rd", {27'd0, link_rd_o}, 32'd0);
    chk("R1 ", "val", link_val_o, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // table walk: R3..R11 and R12 on link request
    for (int i = 0; i < NV; i++) begin
      drive(T_PC[i], T_IN[i], T_A[i], T_B[i]);
      chk(T_TAG[i], "npc", npc_o, T_NPC[i]);
      chk(T_TAG[i], "we", {31'd0, link_we_o}, {31'd0, T_WE[i]});
      chk(T_TAG[i], "rd", {27'd0, link_rd_o}, {27'd0, T_RD[i]});
      chk("R7 ", "val", link_val_o, T_PC[i] + 32'd4);
    end

    // R2: new inputs before the edge leave the outputs unchanged
    drive(32'h00002000, 32'h0C000040, 32'd0, 32'd0);
    @(negedge clk);
    pc_i = 32'h00003000; instr_i = 32'h08000010;
    #1;
    chk("R2 ", "hold npc", npc_o, 32'h00000100);
    chk("R2 ", "hold we", {31'd0, link_we_o}, 32'd1);
    @(posedge clk);
    #1;
    chk("R2 ", "update npc", npc_o, 32'h00000040);
    chk("R12", "we after j", {31'd0, link_we_o}, 32'd0);

    // R1: mid-stream reset overrides a linking jump
    @(negedge clk);
    rst = 1'b1; pc_i = 32'h00004000; instr_i = 32'h0C000001;
    @(posedge clk);
    #1;
    chk("R1 ", "mid npc", npc_o, 32'h0);
    chk("R1 ", "mid we", {31'd0, link_we_o}, 32'd0);
    chk("R1 ", "mid val", link_val_o, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R7 ", "post-reset jal npc", npc_o, 32'h00000004);
    chk("R7 ", "post-reset jal rd", {27'd0, link_rd_o}, 32'd31);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule